// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This combinational unit picks the address of the next instruction for a 64-bit in-order core. It also produces the return address for jumps that save one. Each cycle the core presents the current program counter, both source register values, the decoded immediate, the destination register index and a control-flow operation code. The unit resolves the branch condition, forms the target and reports whether control flow was redirected.

Conditional branches compare the two operands for equality, for signed order or for unsigned order. A taken branch, and also the direct jump, adds the immediate scaled by two to the program counter, because instructions start only on even addresses. The register-indirect jump adds the immediate unscaled to the first operand and forces bit 0 of the result to zero. Both jumps may save the address of the following instruction. That save is suppressed when the destination is register 0, which always reads as zero.

The `imm` input is the sign-extended immediate field. For branches and the direct jump it counts 2-byte units. For the indirect jump it counts bytes.

Top module: `nextpc_unit`

## Requirements
- R1: With `op` = 0 (no control flow) or any code from 9 to 15, `next_pc` = `pc` + 4, `taken` = 0 and `link_we` = 0.
- R2: Code 1 (equal) is taken exactly when `rs1_val` == `rs2_val`. Code 2 (not equal) is taken exactly when they differ.
- R3: Code 3 (less than) is taken when `rs1_val` < `rs2_val` as two's-complement numbers. Code 4 (greater or equal) is taken in the opposite case.
- R4: Code 5 (less than) is taken when `rs1_val` < `rs2_val` as unsigned numbers. Code 6 (greater or equal) is taken in the opposite case.
- R5: A taken branch sets `next_pc` = `pc` + 2*`imm`, modulo 2^64. This covers the extreme field values +2047 and -2048.
- R6: A branch that is not taken sets `next_pc` = `pc` + 4 and `taken` = 0. The addition wraps modulo 2^64.
- R7: Code 7 (direct jump) always sets `taken` = 1 and `next_pc` = `pc` + 2*`imm`. This covers offsets up to the largest 20-bit field.
- R8: Code 8 (indirect jump) always sets `taken` = 1 and `next_pc` = (`rs1_val` + `imm`) with bit 0 cleared.
- R9: `link_val` equals `pc` + 4 for every operation.
- R10: `link_we` is 1 only for codes 7 and 8 with `rd_idx` not equal to 0. It is 0 for every other operation and for `rd_idx` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc | input | 64 | Address of the current instruction |
| rs1_val | input | 64 | First source operand |
| rs2_val | input | 64 | Second source operand |
| imm | input | 64 | Sign-extended immediate |
| op | input | 4 | Control-flow operation code |
| rd_idx | input | 5 | Destination register index |
| next_pc | output | 64 | Address of the next instruction |
| taken | output | 1 | Control flow redirected |
| link_val | output | 64 | Return address to save |
| link_we | output | 1 | Save the return address |

## Verification
The assertions sample the unit whenever its inputs change. They assume that every input holds a defined value and that `op` is a 4-bit code, with codes above 8 carrying no meaning. The bench always drives all inputs together from one task, so every input is defined. It also applies unused codes on purpose to show that they act as no control flow. Operand pairs are chosen so that the signed and unsigned orders disagree, and offsets sit at the extremes of the immediate fields.

// File: rtl/nextpc_unit.sv
module nextpc_unit #(
  parameter int XLEN       = 64,
  parameter int REGW       = 5,
  parameter int OPW        = 4,
  parameter int INSN_BYTES = 4
) (
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] rs1_val,
  input  logic [XLEN-1:0] rs2_val,
  input  logic [XLEN-1:0] imm,
  input  logic [OPW-1:0]  op,
  input  logic [REGW-1:0] rd_idx,
  output logic [XLEN-1:0] next_pc,
  output logic            taken,
  output logic [XLEN-1:0] link_val,
  output logic            link_we
);
  localparam logic [OPW-1:0] OP_NONE = OPW'(0);
  localparam logic [OPW-1:0] OP_EQ   = OPW'(1);
  localparam logic [OPW-1:0] OP_NE   = OPW'(2);
  localparam logic [OPW-1:0] OP_LT   = OPW'(3);
  localparam logic [OPW-1:0] OP_GE   = OPW'(4);
  localparam logic [OPW-1:0] OP_LTU  = OPW'(5);
  localparam logic [OPW-1:0] OP_GEU  = OPW'(6);
  localparam logic [OPW-1:0] OP_JMP  = OPW'(7);
  localparam logic [OPW-1:0] OP_JREG = OPW'(8);

  logic [XLEN-1:0] seq_pc, rel_tgt, ind_sum, ind_tgt;
  logic            same, less_s, less_u, is_jump;

  assign seq_pc  = pc + XLEN'(INSN_BYTES);
  assign rel_tgt = pc + {imm[XLEN-2:0], 1'b0};
  assign ind_sum = rs1_val + imm;
  assign ind_tgt = {ind_sum[XLEN-1:1], 1'b0};

  assign same   = (rs1_val == rs2_val);
  assign less_s = ($signed(rs1_val) < $signed(rs2_val));
  assign less_u = (rs1_val < rs2_val);

  always_comb begin
    taken   = 1'b0;
    next_pc = seq_pc;
    unique case (op)
      OP_EQ:   taken = same;
      OP_NE:   taken = !same;
      OP_LT:   taken = less_s;
      OP_GE:   taken = !less_s;
      OP_LTU:  taken = less_u;
      OP_GEU:  taken = !less_u;
      OP_JMP:  taken = 1'b1;
      OP_JREG: taken = 1'b1;
      default: taken = 1'b0;
    endcase
    if (taken) next_pc = (op == OP_JREG) ? ind_tgt : rel_tgt;
  end

  assign is_jump  = (op == OP_JMP) || (op == OP_JREG);
  assign link_val = seq_pc;
  assign link_we  = is_jump && (rd_idx != '0);
endmodule

// File: rtl/nextpc_unit_chk.sv
module nextpc_unit_chk #(
  parameter int XLEN = 64,
  parameter int REGW = 5,
  parameter int OPW  = 4
) (
  input logic [XLEN-1:0] pc,
  input logic [XLEN-1:0] rs1_val,
  input logic [XLEN-1:0] rs2_val,
  input logic [XLEN-1:0] imm,
  input logic [OPW-1:0]  op,
  input logic [REGW-1:0] rd_idx,
  input logic [XLEN-1:0] next_pc,
  input logic            taken,
  input logic [XLEN-1:0] link_val,
  input logic            link_we
);
  always_comb begin
    if (op == OPW'(0) || op > OPW'(8))
      AST_IDLE_NOT_TAKEN: assert (!taken && !link_we); // R1
    if (op == OPW'(1) || op == OPW'(2))
      AST_EQ_PAIR: assert (taken == ((op == OPW'(1)) == (rs1_val == rs2_val))); // R2
    if (op == OPW'(3) && rs1_val[XLEN-1] != rs2_val[XLEN-1])
      AST_SIGNED_SIGNBIT: assert (taken == rs1_val[XLEN-1]); // R3
    if (op == OPW'(5) && rs1_val[XLEN-1] != rs2_val[XLEN-1])
      AST_UNSIGNED_TOPBIT: assert (taken == rs2_val[XLEN-1]); // R4
    if (!taken)
      AST_FALLTHRU_SEQ: assert (next_pc == link_val); // R6
    if (op == OPW'(7))
      AST_JMP_TAKEN: assert (taken && next_pc[0] == pc[0]); // R7
    if (op == OPW'(8))
      AST_JREG_EVEN: assert (taken && !next_pc[0]); // R8
    if (link_we)
      AST_LINK_ONLY_JUMP: assert ((op == OPW'(7) || op == OPW'(8)) && rd_idx != '0); // R10
  end
endmodule

bind nextpc_unit nextpc_unit_chk #(.XLEN(XLEN), .REGW(REGW), .OPW(OPW)) u_chk (
  .pc(pc), .rs1_val(rs1_val), .rs2_val(rs2_val), .imm(imm), .op(op),
  .rd_idx(rd_idx), .next_pc(next_pc), .taken(taken), .link_val(link_val),
  .link_we(link_we)
);

// File: tb/nextpc_unit_tb.sv
`timescale 1ns/1ps
module nextpc_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [63:0] pc, rs1_val, rs2_val, imm;
  logic [3:0]  op;
  logic [4:0]  rd_idx;
  logic [63:0] next_pc, link_val;
  logic        taken, link_we;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  nextpc_unit u_dut (
    .pc(pc), .rs1_val(rs1_val), .rs2_val(rs2_val), .imm(imm), .op(op),
    .rd_idx(rd_idx), .next_pc(next_pc), .taken(taken), .link_val(link_val),
    .link_we(link_we)
  );

  task automatic drive(input logic [3:0] o, input logic [63:0] p, a, b, i,
                       input logic [4:0] rd);
    @(negedge clk);
    op = o; pc = p; rs1_val = a; rs2_val = b; imm = i; rd_idx = rd;
    #1;
  endtask

  task automatic expect_out(input string req, input logic [63:0] e_pc,
                            input logic e_tk, input logic e_we);
    n_chk++;
    if (next_pc !== e_pc || taken !== e_tk || link_we !== e_we || link_val !== pc + 64'd4) begin
      n_bad++;
      $display("FAIL %s: next_pc=%h taken=%b link_we=%b link=%h expected %h %b %b %h",
               req, next_pc, taken, link_we, link_val, e_pc, e_tk, e_we, pc + 64'd4);
    end
  endtask

  task automatic t_reset_idle();
    drive(4'd0, 64'h1000, 64'd0, 64'd0, 64'd0, 5'd0);
    expect_out("R1 idle after reset", 64'h1004, 1'b0, 1'b0);
  endtask

  task automatic t_unused_codes();
    drive(4'd12, 64'h2000, 64'd3, 64'd3, 64'd40, 5'd1);
    expect_out("R1 code 12", 64'h2004, 1'b0, 1'b0);
    drive(4'd15, 64'h2000, 64'd3, 64'd3, 64'd40, 5'd7);
    expect_out("R1 code 15", 64'h2004, 1'b0, 1'b0);
  endtask

  task automatic t_equality();
    drive(4'd1, 64'h1000, 64'd5, 64'd5, 64'd8, 5'd3);
    expect_out("R2 eq equal", 64'h1010, 1'b1, 1'b0);
    drive(4'd2, 64'h1000, 64'd5, 64'd5, 64'd8, 5'd3);
    expect_out("R2 ne equal", 64'h1004, 1'b0, 1'b0);
    drive(4'd2, 64'h1000, 64'd5, 64'd6, 64'd8, 5'd3);
    expect_out("R2 ne differ", 64'h1010, 1'b1, 1'b0);
  endtask

  task automatic t_signed_unsigned();
    drive(4'd3, 64'h1000, '1, 64'd1, -64'sd4, 5'd0);
    expect_out("R3 lt -1<1", 64'h0FF8, 1'b1, 1'b0);
    drive(4'd4, 64'h1000, '1, 64'd1, -64'sd4, 5'd0);
    expect_out("R3 ge -1,1", 64'h1004, 1'b0, 1'b0);
    drive(4'd5, 64'h1000, '1, 64'd1, -64'sd4, 5'd0);
    expect_out("R4 ltu max,1", 64'h1004, 1'b0, 1'b0);
    drive(4'd6, 64'h1000, '1, 64'd1, -64'sd4, 5'd0);
    expect_out("R4 geu max,1", 64'h0FF8, 1'b1, 1'b0);
    drive(4'd3, 64'h1000, 64'd9, 64'd9, 64'd4, 5'd0);
    expect_out("R3 lt equal", 64'h1004, 1'b0, 1'b0);
    drive(4'd4, 64'h1000, 64'd9, 64'd9, 64'd4, 5'd0);
    expect_out("R3 ge equal", 64'h1008, 1'b1, 1'b0);
    drive(4'd5, 64'h1000, 64'd9, 64'd9, 64'd4, 5'd0);
    expect_out("R4 ltu equal", 64'h1004, 1'b0, 1'b0);
  endtask

  task automatic t_branch_reach();
    drive(4'd1, 64'h10000, 64'd0, 64'd0, 64'd2047, 5'd0);
    expect_out("R5 max fwd", 64'h10FFE, 1'b1, 1'b0);
    drive(4'd1, 64'h10000, 64'd0, 64'd0, -64'sd2048, 5'd0);
    expect_out("R5 max back", 64'hF000, 1'b1, 1'b0);
    drive(4'd2, 64'hFFFF_FFFF_FFFF_FFFC, 64'd1, 64'd1, 64'd2, 5'd0);
    expect_out("R6 wrap", 64'd0, 1'b0, 1'b0);
  endtask

  task automatic t_direct_jump();
    drive(4'd7, 64'h1000, 64'd0, 64'd0, 64'h7FFFF, 5'd1);
    expect_out("R7 jmp far", 64'h100FFE, 1'b1, 1'b1);
    drive(4'd7, 64'h1000, 64'd0, 64'd0, -64'sd16, 5'd0);
    expect_out("R10 jmp rd0", 64'h0FE0, 1'b1, 1'b0);
  endtask

  task automatic t_indirect_jump();
    drive(4'd8, 64'h4000, 64'h2003, 64'd0, 64'd4, 5'd5);
    expect_out("R8 jreg odd", 64'h2006, 1'b1, 1'b1);
    drive(4'd8, 64'h4000, 64'h2003, 64'd0, -64'sd3, 5'd0);
    expect_out("R8 jreg neg rd0", 64'h2000, 1'b1, 1'b0);
    drive(4'd8, 64'h4000, 64'h2000, 64'd0, 64'd0, 5'd31);
    n_chk++;
    if (link_val !== 64'h4004) begin
      n_bad++;
      $display("FAIL R9 link: %h expected %h", link_val, 64'h4004);
    end
  endtask

  initial begin
    op = '0; pc = '0; rs1_val = '0; rs2_val = '0; imm = '0; rd_idx = '0;
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    t_reset_idle();
    t_unused_codes();
    t_equality();
    t_signed_unsigned();
    t_branch_reach();
    t_direct_jump();
    t_indirect_jump();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule